// File: doc/BRIEF.md
# Vectored Power-On and Display Interrupt Controller

This block raises interrupt requests to a small processor from two sources and supplies the vector that the processor reads during the acknowledge cycle. The first source is a power-on request. A power-on pulse sets it, and it steers the processor to a fixed start address. The second source is a display-update request. It is raised only after the block has emitted a timed, active-low strobe to the display driver, in response to a device-select strobe from the address decoder.

The processor removes the request line by dropping its interrupt enable. It then raises acknowledge and reads the 8-bit vector from the data bus. The source being served is chosen when acknowledge rises. That source's flag is cleared when acknowledge falls, so the vector stays valid for the whole acknowledge window. The power-on source wins when both are pending, and the display request waits for the next acknowledge. All state changes happen on the rising clock edge, and reset is synchronous and active high.

Top module: `vint_ctrl`

## Requirements
- R1: A `por_pulse` sampled high sets the power-on flag. From the next cycle on, `irq` is high whenever `int_en` is high.
- R2: While `int_ack` is high and the power-on source is selected, `vec_oe` is 1 and `vec_data` is 0xFC (bits 7..2 high, bits 1..0 low).
- R3: A falling edge of `int_ack` clears the flag of the source that was selected. A cleared power-on flag stays clear until the next `por_pulse`.
- R4: A `dev_sel` sampled high while no strobe is running drives `disp_strobe_n` low for exactly `PULSE_CYC` cycles, starting in the next cycle.
- R5: The display flag is set in the same cycle in which `disp_strobe_n` returns high, and never while the strobe is low.
- R6: With `int_en` low, `irq` is low. Pending flags are kept and reappear on `irq` when `int_en` returns high.
- R7: While `int_ack` is high and the display source is selected, `vec_oe` is 1 and `vec_data` is 0xFF.
- R8: A `dev_sel` sampled high while the strobe is low is ignored. It neither lengthens the pulse nor adds a second request.
- R9: The source is chosen from the flags when `int_ack` rises, and the power-on flag takes priority. A display request pending at the same time stays set and is served by the following acknowledge.
- R10: When `int_ack` is low, or when no flag was pending as acknowledge rose, `vec_oe` is 0 and `vec_data` is 0x00.
- R11: After reset, `irq` is 0, `vec_oe` is 0, `vec_data` is 0x00 and `disp_strobe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_pulse | input | 1 | Power-on pulse; sets the power-on request |
| dev_sel | input | 1 | Device-select strobe from the address decoder |
| int_en | input | 1 | Processor interrupt enable; low masks `irq` |
| int_ack | input | 1 | Processor interrupt acknowledge |
| irq | output | 1 | Interrupt request to the processor |
| vec_oe | output | 1 | Data bus drive enable for the vector |
| vec_data | output | 8 | Interrupt vector, 0x00 when not driven |
| disp_strobe_n | output | 1 | Active-low display driver strobe |

## Verification
The vector path is tried with a power-on request alone, a display request alone, both pending together, and an acknowledge with nothing pending. These cases separate the 0xFC and 0xFF codes, the priority order and the released bus. The strobe path is started once cleanly and once with a second select in the middle of the pulse. This shows whether the pulse length is fixed and whether the display request appears only at its end. Toggling the enable while flags are pending separates masking the request line from losing the request.

// File: rtl/vint_pkg.sv
package vint_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BOOT = 2'd1,
        SRC_DISP = 2'd2
    } src_e;

    localparam logic [7:0] BOOT_VECTOR = 8'hFC;
    localparam logic [7:0] DISP_VECTOR = 8'hFF;
    localparam logic [7:0] IDLE_VECTOR = 8'h00;

    typedef struct packed {
        logic       oe;
        logic [7:0] data;
    } bus_drive_t;

    function automatic src_e pick_source(input logic boot, input logic disp);
        if (boot)      return SRC_BOOT;
        else if (disp) return SRC_DISP;
        else           return SRC_NONE;
    endfunction

    function automatic bus_drive_t drive_for(input src_e src, input logic ack);
        bus_drive_t d;
        d.oe   = 1'b0;
        d.data = IDLE_VECTOR;
        if (ack) begin
            case (src)
                SRC_BOOT: begin d.oe = 1'b1; d.data = BOOT_VECTOR; end
                SRC_DISP: begin d.oe = 1'b1; d.data = DISP_VECTOR; end
                default:  begin d.oe = 1'b0; d.data = IDLE_VECTOR; end
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/vint_strobe_timer.sv
module vint_strobe_timer #(
    parameter int PULSE_CYC = 200_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    output logic strobe_n_o,
    output logic done_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

    logic          active_q;
    logic [CW-1:0] left_q;

    assign done_o     = active_q && (left_q == '0);
    assign strobe_n_o = ~active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            left_q   <= '0;
        end else if (active_q) begin
            if (left_q == '0) begin
                active_q <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end else if (sel_i) begin
            active_q <= 1'b1;
            left_q   <= LOAD;
        end
    end
endmodule

// File: rtl/vint_req_flags.sv
module vint_req_flags
    import vint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic por_i,
    input  logic disp_set_i,
    input  logic ack_i,
    output logic boot_o,
    output logic disp_o,
    output src_e src_o
);
    logic boot_q, disp_q, ack_q;
    src_e held_q;
    logic ack_rise, ack_fall;

    assign ack_rise = ack_i & ~ack_q;
    assign ack_fall = ~ack_i & ack_q;

    assign boot_o = boot_q;
    assign disp_o = disp_q;
    assign src_o  = ack_q ? held_q : pick_source(boot_q, disp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_q <= 1'b0;
            disp_q <= 1'b0;
            ack_q  <= 1'b0;
            held_q <= SRC_NONE;
        end else begin
            ack_q <= ack_i;
            if (ack_rise) begin
                held_q <= pick_source(boot_q, disp_q);
            end
            if (por_i) begin
                boot_q <= 1'b1;
            end else if (ack_fall && held_q == SRC_BOOT) begin
                boot_q <= 1'b0;
            end
            if (disp_set_i) begin
                disp_q <= 1'b1;
            end else if (ack_fall && held_q == SRC_DISP) begin
                disp_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vint_vec_drive.sv
module vint_vec_drive
    import vint_pkg::*;
(
    input  logic       en_i,
    input  logic       ack_i,
    input  logic       boot_i,
    input  logic       disp_i,
    input  src_e       src_i,
    output logic       irq_o,
    output logic       oe_o,
    output logic [7:0] data_o
);
    bus_drive_t drv;

    always_comb begin
        drv    = drive_for(src_i, ack_i);
        irq_o  = en_i & (boot_i | disp_i);
        oe_o   = drv.oe;
        data_o = drv.data;
    end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
#(
    parameter int PULSE_CYC = 200_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_pulse,
    input  logic       dev_sel,
    input  logic       int_en,
    input  logic       int_ack,
    output logic       irq,
    output logic       vec_oe,
    output logic [7:0] vec_data,
    output logic       disp_strobe_n
);
    logic strobe_done;
    logic boot_pend, disp_pend;
    src_e cur_src;

    vint_strobe_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (dev_sel),
        .strobe_n_o(disp_strobe_n),
        .done_o    (strobe_done)
    );

    vint_req_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .por_i     (por_pulse),
        .disp_set_i(strobe_done),
        .ack_i     (int_ack),
        .boot_o    (boot_pend),
        .disp_o    (disp_pend),
        .src_o     (cur_src)
    );

    vint_vec_drive u_vec (
        .en_i  (int_en),
        .ack_i (int_ack),
        .boot_i(boot_pend),
        .disp_i(disp_pend),
        .src_i (cur_src),
        .irq_o (irq),
        .oe_o  (vec_oe),
        .data_o(vec_data)
    );
endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk #(
    parameter int PULSE_CYC = 200_000
) (
    input logic       clk,
    input logic       rst,
    input logic       por_pulse,
    input logic       int_en,
    input logic       int_ack,
    input logic       irq,
    input logic       vec_oe,
    input logic [7:0] vec_data,
    input logic       disp_strobe_n
);
    int low_len;

    always_ff @(posedge clk) begin
        if (rst || disp_strobe_n) low_len <= 0;
        else                      low_len <= low_len + 1;
    end

    p_por_sets_r1: assert property (@(posedge clk) disable iff (rst)
        por_pulse |=> (irq || !int_en));

    p_vec_code_r2: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> (vec_data == 8'hFC || vec_data == 8'hFF));

    p_strobe_len_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_strobe_n) |-> (low_len == PULSE_CYC));

    p_req_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(disp_strobe_n) && int_en) |-> irq);

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq);

    p_bus_released_r10: assert property (@(posedge clk) disable iff (rst)
        !int_ack |-> (!vec_oe && vec_data == 8'h00));
endmodule

bind vint_ctrl vint_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .por_pulse    (por_pulse),
    .int_en       (int_en),
    .int_ack      (int_ack),
    .irq          (irq),
    .vec_oe       (vec_oe),
    .vec_data     (vec_data),
    .disp_strobe_n(disp_strobe_n)
);

// File: tb/sim_vint_ctrl.sv
`timescale 1ns/1ps
module sim_vint_ctrl;
    localparam int PULSE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0, sel = 1'b0, en = 1'b0, ack = 1'b0;
    logic irq, oe, stb_n;
    logic [7:0] data;

    always #2.5 clk = ~clk;

    vint_ctrl #(.PULSE_CYC(PULSE)) u0 (
        .clk(clk), .rst(rst), .por_pulse(por), .dev_sel(sel),
        .int_en(en), .int_ack(ack), .irq(irq), .vec_oe(oe),
        .vec_data(data), .disp_strobe_n(stb_n)
    );

    typedef struct packed {
        logic       irq;
        logic       oe;
        logic [7:0] data;
        logic       stb_n;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state: 0 none, 1 power-on, 2 display
    logic m_boot = 0, m_disp = 0, m_ackq = 0;
    int   m_sel = 0, m_left = 0;

    task automatic model_edge();
        logic fin, rise, fall;
        if (rst) begin
            m_boot = 0; m_disp = 0; m_ackq = 0; m_sel = 0; m_left = 0;
        end else begin
            fin  = (m_left == 1);
            rise = ack && !m_ackq;
            fall = !ack && m_ackq;
            if (fall && m_sel == 1) m_boot = 0;
            if (fall && m_sel == 2) m_disp = 0;
            if (rise) m_sel = m_boot ? 1 : (m_disp ? 2 : 0);
            if (por) m_boot = 1;
            if (fin) m_disp = 1;
            if (m_left > 0) m_left--;
            else if (sel) m_left = PULSE;
            m_ackq = ack;
        end
    endtask

    function automatic obs_t model_out();
        obs_t o;
        int cur;
        cur     = m_ackq ? m_sel : (m_boot ? 1 : (m_disp ? 2 : 0));
        o.irq   = en && (m_boot || m_disp);
        o.oe    = ack && cur != 0;
        o.data  = !o.oe ? 8'h00 : (cur == 1 ? 8'hFC : 8'hFF);
        o.stb_n = (m_left == 0);
        return o;
    endfunction

    task automatic step(input logic r, input logic p, input logic s,
                        input logic e, input logic a, input string tag);
        @(posedge clk);
        model_edge();
        #1;
        rst = r; por = p; sel = s; en = e; ack = a;
        exp_q.push_back(model_out());
        tag_q.push_back(tag);
    endtask

    obs_t  m_exp, m_act;
    string m_tag;
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            m_exp = exp_q.pop_front();
            m_tag = tag_q.pop_front();
            m_act = '{irq: irq, oe: oe, data: data, stb_n: stb_n};
            n_chk++;
            if (m_act !== m_exp) begin
                n_bad++;
                $display("FAIL %s: {irq,oe,data,stb_n} actual %b %b %h %b expected %b %b %h %b",
                         m_tag, m_act.irq, m_act.oe, m_act.data, m_act.stb_n,
                         m_exp.irq, m_exp.oe, m_exp.data, m_exp.stb_n);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 1, 0, "R11");
        // R1 power-on request
        step(0, 1, 0, 1, 0, "R1");
        for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 0, "R1");
        // R6 masking keeps the flag
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 1, 0, "R6");
        // R2 vector during acknowledge, R3 clear at trailing edge
        step(0, 0, 0, 0, 1, "R2");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R2");
        step(0, 0, 0, 0, 0, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R3");
        // R10 acknowledge with nothing pending
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 1, 0, "R10");
        // R4/R5 strobe, R8 select during pulse ignored
        step(0, 0, 1, 1, 0, "R4");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R5");
        step(0, 0, 1, 1, 0, "R8");
        step(0, 0, 1, 1, 0, "R8");
        for (int i = 0; i < PULSE + 3; i++) step(0, 0, 0, 1, 0, "R4");
        // R7 display vector
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 1, 0, "R7");
        // R9 priority: display pending, then power-on
        step(0, 0, 1, 1, 0, "R9");
        for (int i = 0; i < PULSE + 2; i++) step(0, 0, 0, 1, 0, "R9");
        step(0, 1, 0, 1, 0, "R9");
        step(0, 0, 0, 1, 0, "R9");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 1, 0, "R9");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R9");
        // R3 power-on flag re-arms only with a new pulse
        step(0, 1, 0, 1, 0, "R3");
        step(0, 0, 0, 1, 0, "R3");
        // reset clears pending flags
        step(1, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 1, 0, "R11");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule